// File: doc/BRIEF.md
# Force-Shutdown Controller

The block performs an emergency shutdown of a group of sequenced power channels when there is no time for an orderly power-down. A shutdown can be triggered by an active-low pin or by a software command bit. Once triggered, every channel enable is forced inactive in the same cycle and the power-on request line is pulled low. The block then waits until every supply reports that it is below its OFF threshold. When that happens, and the pin is no longer low, it sends a single-cycle restart pulse to the power-on sequencer.

The pin is asynchronous and passes through a two-flop synchroniser before use. The software bit is set by a one-cycle request and is cleared by hardware once the supplies have collapsed. While a graceful power-off sequence is running, the block ignores both triggers, so it cannot start a shutdown in that time.

Top module: `fsd_ctrl`

## Requirements
- R1: After reset, `shutdown_active`, `pwr_on_low`, `restart_pulse` and `sw_fs_bit` are 0, and `ch_en` equals `seq_en`.
- R2: A low level on `fs_pin_n` is seen through a two-stage synchroniser. `shutdown_active` rises on the third rising clock edge after the low level is first sampled, provided `pwroff_active` is 0.
- R3: While `shutdown_active` is 1, every bit of `ch_en` is 0 whatever `seq_en` holds. Otherwise `ch_en` equals `seq_en`.
- R4: `pwr_on_low` is 1 for exactly the cycles in which `shutdown_active` is 1.
- R5: A one-cycle `sw_fs_req` with `pwroff_active` at 0 sets `sw_fs_bit` on the next edge. While the block is idle, the set bit starts a shutdown on the edge after that.
- R6: `sw_fs_bit` is cleared on the edge at which the block is shut down and all bits of `below_off` are 1, unless `sw_fs_req` is high in that same cycle.
- R7: While `pwroff_active` is 1, no shutdown starts and `sw_fs_req` does not set `sw_fs_bit`.
- R8: A shutdown ends only on an edge where all bits of `below_off` are 1 and the synchronised pin is high. On that edge `restart_pulse` goes to 1 as `shutdown_active` goes to 0.
- R9: If the synchronised pin is still low when all supplies are below threshold, the block stays shut down and gives no restart pulse until the pin has been high through the synchroniser.
- R10: `restart_pulse` is high for exactly one cycle per shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_pin_n | input | 1 | Asynchronous active-low force-shutdown pin |
| sw_fs_req | input | 1 | One-cycle request that sets the software shutdown bit |
| below_off | input | NCH | Per-channel flag: supply is below its OFF threshold |
| pwroff_active | input | 1 | A graceful power-off sequence is in progress |
| seq_en | input | NCH | Channel enables from the sequencer |
| ch_en | output | NCH | Channel enables after shutdown gating |
| pwr_on_low | output | 1 | Pulls the power-on request line low |
| restart_pulse | output | 1 | One-cycle restart request to the power-on sequencer |
| sw_fs_bit | output | 1 | Current value of the software shutdown bit |
| shutdown_active | output | 1 | The block is in forced shutdown |

## Verification
A wrong shutdown state shows up in the same cycle on `ch_en` and `pwr_on_low`. A shutdown state that is left too early or too late moves `restart_pulse` off the edge where the supplies have collapsed. A software bit that is not cleared causes a second shutdown one edge after the restart, so the per-clock comparison catches it within two cycles. A pin synchroniser of the wrong depth moves the edge of `shutdown_active` by one cycle, and the R2 and R9 edge checks report it.

// File: rtl/fsd_ctrl.sv
module fsd_ctrl #(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fs_pin_n,
  input  logic           sw_fs_req,
  input  logic [NCH-1:0] below_off,
  input  logic           pwroff_active,
  input  logic [NCH-1:0] seq_en,
  output logic [NCH-1:0] ch_en,
  output logic           pwr_on_low,
  output logic           restart_pulse,
  output logic           sw_fs_bit,
  output logic           shutdown_active
);

  logic [SYNC_STAGES-1:0] pin_sync;
  logic                   pin_hi;
  logic                   all_below;
  logic                   trigger;
  logic                   release_now;

  assign pin_hi      = pin_sync[SYNC_STAGES-1];
  assign all_below   = &below_off;
  assign trigger     = (~pin_hi | sw_fs_bit) & ~pwroff_active;
  assign release_now = shutdown_active & all_below & pin_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sync <= '1;
    else        pin_sync <= {pin_sync[SYNC_STAGES-2:0], fs_pin_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_active <= 1'b0;
      restart_pulse   <= 1'b0;
      sw_fs_bit       <= 1'b0;
    end else begin
      restart_pulse <= release_now;
      if (shutdown_active) shutdown_active <= ~release_now;
      else                 shutdown_active <= trigger;
      if (sw_fs_req && !pwroff_active)      sw_fs_bit <= 1'b1;
      else if (shutdown_active && all_below) sw_fs_bit <= 1'b0;
    end
  end

  assign ch_en      = seq_en & {NCH{~shutdown_active}};
  assign pwr_on_low = shutdown_active;

endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sw_fs_req,
  input logic [NCH-1:0] below_off,
  input logic           pwroff_active,
  input logic [NCH-1:0] ch_en,
  input logic           pwr_on_low,
  input logic           restart_pulse,
  input logic           sw_fs_bit,
  input logic           shutdown_active
);

  p_chen_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_active |-> ch_en == '0);

  p_pwr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on_low) |-> restart_pulse);

  p_swclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_active && (&below_off) && !sw_fs_req |=> !sw_fs_bit);

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_active && pwroff_active |=> !shutdown_active);

  p_restart_collapse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> $past(&below_off) && $past(shutdown_active) && !shutdown_active);

  p_restart_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);

endmodule

bind fsd_ctrl fsd_checker #(.NCH(NCH)) u_fsd_checker (
  .clk(clk), .rst_n(rst_n), .sw_fs_req(sw_fs_req), .below_off(below_off),
  .pwroff_active(pwroff_active), .ch_en(ch_en), .pwr_on_low(pwr_on_low),
  .restart_pulse(restart_pulse), .sw_fs_bit(sw_fs_bit),
  .shutdown_active(shutdown_active)
);

// File: tb/tb_fsd_ctrl.sv
`timescale 1ns/1ps
module tb_fsd_ctrl;
  localparam int NCH = 8;

  logic clk = 0, rst_n = 0;
  logic fs_pin_n = 1, sw_fs_req = 0, pwroff_active = 0;
  logic [NCH-1:0] below_off = '0, seq_en = '0;
  logic [NCH-1:0] ch_en;
  logic pwr_on_low, restart_pulse, sw_fs_bit, shutdown_active;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0, cmp_on = 0;

  always #2.5 clk = ~clk;

  fsd_ctrl #(.NCH(NCH)) dut (.*);

  // behavioural reference
  int pin_q[$];
  bit m_shut, m_rst, m_sw, m_pin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q = '{1, 1}; m_shut = 0; m_rst = 0; m_sw = 0; m_pin = 1;
    end else begin
      bit all, nshut, nrst, nsw;
      all   = (below_off == '1);
      m_pin = pin_q[0];
      nrst  = m_shut && all && m_pin;
      nshut = m_shut ? !nrst : ((!m_pin || m_sw) && !pwroff_active);
      if (sw_fs_req && !pwroff_active) nsw = 1;
      else if (m_shut && all) nsw = 0;
      else nsw = m_sw;
      void'(pin_q.pop_front());
      pin_q.push_back(int'(fs_pin_n));
      m_shut = nshut; m_rst = nrst; m_sw = nsw;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 shutdown_active", 32'(shutdown_active), 32'(m_shut));
    chk("R3 ch_en", 32'(ch_en), m_shut ? 32'd0 : 32'(seq_en));
    chk("R4 pwr_on_low", 32'(pwr_on_low), 32'(m_shut));
    chk("R8 restart_pulse", 32'(restart_pulse), 32'(m_rst));
    chk("R6 sw_fs_bit", 32'(sw_fs_bit), 32'(m_sw));
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    seq_en = 8'hA5;
    step(2); rst_n = 1; step(1);
    cmp_on = 1;
    // R1 reset state
    chk("R1 shut", 32'(shutdown_active), 0);
    chk("R1 restart", 32'(restart_pulse), 0);
    chk("R1 swbit", 32'(sw_fs_bit), 0);
    chk("R1 ch_en", 32'(ch_en), 32'h A5);

    // R2: pin low, shutdown on third edge
    fs_pin_n = 0; step(2);
    chk("R2 not yet", 32'(shutdown_active), 0);
    step(1);
    chk("R2 shut on 3rd edge", 32'(shutdown_active), 1);
    seq_en = 8'hFF; step(1);
    chk("R3 all off", 32'(ch_en), 0);
    // R9: collapse while pin still low
    below_off = '1; step(5);
    chk("R9 held", 32'(shutdown_active), 1);
    chk("R9 no restart", 32'(restart_pulse), 0);
    fs_pin_n = 1; step(2);
    chk("R9 still shut", 32'(shutdown_active), 1);
    step(1);
    chk("R8 released", 32'(shutdown_active), 0);
    chk("R8 restart", 32'(restart_pulse), 1);
    step(1);
    chk("R10 single pulse", 32'(restart_pulse), 0);
    below_off = '0; seq_en = 8'h3C; step(2);

    // R5/R6: software trigger
    sw_fs_req = 1; step(1); sw_fs_req = 0;
    chk("R5 bit set", 32'(sw_fs_bit), 1);
    chk("R5 not shut yet", 32'(shutdown_active), 0);
    step(1);
    chk("R5 shut", 32'(shutdown_active), 1);
    below_off = 8'h7F; step(3);
    chk("R6 partial keeps bit", 32'(sw_fs_bit), 1);
    below_off = '1; step(1);
    chk("R6 cleared", 32'(sw_fs_bit), 0);
    chk("R8 sw restart", 32'(restart_pulse), 1);
    step(1);
    chk("R10 sw single", 32'(restart_pulse), 0);
    chk("R6 no retrigger", 32'(shutdown_active), 0);
    below_off = '0; step(2);

    // R7: masked during graceful power-off
    pwroff_active = 1; fs_pin_n = 0; step(6);
    chk("R7 pin masked", 32'(shutdown_active), 0);
    sw_fs_req = 1; step(1); sw_fs_req = 0;
    chk("R7 sw ignored", 32'(sw_fs_bit), 0);
    fs_pin_n = 1; step(4);
    pwroff_active = 0; step(3);
    chk("R7 stays idle", 32'(shutdown_active), 0);

    // mixed patterns, R3 across seq_en values
    for (int k = 0; k < 40; k++) begin
      seq_en = 8'(k * 37 + 11);
      fs_pin_n = (k % 13) > 3;
      below_off = ((k % 7) > 2) ? '1 : 8'(k);
      sw_fs_req = (k % 11) == 5;
      pwroff_active = (k % 17) == 9;
      step(1);
    end
    sw_fs_req = 0; pwroff_active = 0; fs_pin_n = 1; below_off = '1; step(6);
    chk("R8 final idle", 32'(shutdown_active), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule